// File: doc/BRIEF.md
# CCK Symbol Correlator and Largest-Output Picker

This block detects complementary-code-keyed symbols. A block of eight received complex chips is loaded on a start strobe. It is correlated against either 4 or 64 candidate codewords, depending on the rate. The block then reports the index of the strongest candidate, along with that candidate's complex correlation value. The index carries 2 or 6 of the symbol's data bits. A differential phase decoder downstream takes the complex value and recovers the remaining two bits from its phase.

The 64 correlations are not built as separate correlators. A three-stage quaternary Walsh butterfly tree shares the partial sums. The first two stages are computed once from the latched chips. The last stage is evaluated for one candidate per clock while a running maximum keeps the winner. The time to a result depends only on the mode.

Top module: `cck_walsh_picker`

## Requirements
- R1: While reset is held, and after it until the first result, `done` is 0 and `symIdx`, `winI` and `winQ` are 0.
- R2: In 64-code mode (`mode64`=1) candidate k has phases p2=k[1:0], p3=k[3:2], p4=k[5:4], each a multiple of 90 degrees. Chip n (chip 0 first in time) has code phase p2+p3+p4, p3+p4, p2+p4, p4+2, p2+p3, p3, p2+2, 0 for n=0..7. The correlation is the sum over n of r_n times e^(-j*90deg*phase_n).
- R3: In 4-code mode (`mode64`=0) candidate k in 0..3 uses p2 = k[0] ? 3 : 1, p3 = 0 and p4 = k[1] ? 2 : 0. `symIdx[5:2]` is 0 in that mode.
- R4: `winI`/`winQ` carry the real and imaginary parts of the winning candidate's correlation, so the common phase of the received block is kept.
- R5: Candidates are ranked by |I|+|Q|. When two candidates have equal rank, the lower index wins.
- R6: `start` is accepted on a rising edge while the block is idle. `done` is then high for exactly one cycle, after the 64th rising edge (64-code mode) or the 4th rising edge (4-code mode) that follows the accepting edge.
- R7: While a search is running, `start`, `mode64` and the chip inputs have no effect on the result. A start strobe given during a search does not produce an extra `done`.
- R8: `symIdx`, `winI` and `winQ` change only in the cycle that `done` is high, and hold their values until the next result.
- R9: Chips are signed two's-complement values of `CHIP_W` bits. The full range, including the most negative value, gives correct sums without overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Load chips and begin a search |
| mode64 | input | 1 | 1 = 64-code set, 0 = 4-code set |
| chipI | input | 8*CHIP_W | Real parts, chip n at bits [n*CHIP_W +: CHIP_W] |
| chipQ | input | 8*CHIP_W | Imaginary parts, same packing |
| done | output | 1 | One-cycle result strobe |
| symIdx | output | 6 | Winning candidate index |
| winI | output | CHIP_W+4 | Winner correlation, real part |
| winQ | output | CHIP_W+4 | Winner correlation, imaginary part |

## Verification
The inputs are held steady before the accepting edge. `done` and all three results are then due in the cycle after the 64th edge in 64-code mode, or after the 4th edge in 4-code mode. The bench counts falling edges from the accepting edge. It samples `done` one cycle before, at, and one cycle after that point, and reads the results at the due point. The ignore and hold tests read the outputs at the same due point, or over a window with no start. A counter in the checker gives the same window from the ports alone.

// File: rtl/cck_pkg.sv
package cck_pkg;
  localparam int NCHIP      = 8;
  localparam int IDX_W      = 6;
  localparam int NARROW_LAST = 3;

  typedef struct packed {
    logic             load;      // latch chips
    logic             eval;      // evaluate one candidate
    logic             first;     // first candidate of a search
    logic             finish;    // last candidate, publish result
    logic [IDX_W-1:0] candCode;  // {p4,p3,p2} phases of candidate
    logic [IDX_W-1:0] candIdx;   // reported index of candidate
  } ctrl_t;
endpackage

// File: rtl/cck_ctrl.sv
module cck_ctrl
  import cck_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  start,
  input  logic  mode64,
  output ctrl_t ctrl
);
  localparam logic [IDX_W-1:0] WIDE_LAST = {IDX_W{1'b1}};

  typedef enum logic {IDLE, SCAN} state_t;
  state_t           state;
  logic [IDX_W-1:0] cnt;
  logic             wideMode;
  logic             lastCand;

  assign lastCand = wideMode ? (cnt == WIDE_LAST) : (cnt == IDX_W'(NARROW_LAST));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= IDLE;
      cnt      <= '0;
      wideMode <= 1'b0;
    end else begin
      unique case (state)
        IDLE: if (start) begin
          state    <= SCAN;
          cnt      <= '0;
          wideMode <= mode64;
        end
        SCAN: begin
          cnt <= cnt + 1'b1;
          if (lastCand) state <= IDLE;
        end
        default: state <= IDLE;
      endcase
    end
  end

  always_comb begin
    ctrl.load    = (state == IDLE) && start;
    ctrl.eval    = (state == SCAN);
    ctrl.first   = (state == SCAN) && (cnt == '0);
    ctrl.finish  = (state == SCAN) && lastCand;
    ctrl.candIdx = cnt;
    // narrow set: p4 in {0,2}, p3 = 0, p2 in {1,3}
    ctrl.candCode = wideMode ? cnt : {cnt[1], 1'b0, 2'b00, cnt[0], 1'b1};
  end
endmodule

// File: rtl/cck_datapath.sv
module cck_datapath
  import cck_pkg::*;
#(
  parameter int CHIP_W = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  ctrl_t                        ctrl,
  input  logic [NCHIP*CHIP_W-1:0]      chipI,
  input  logic [NCHIP*CHIP_W-1:0]      chipQ,
  output logic                         done,
  output logic [IDX_W-1:0]             symIdx,
  output logic signed [CHIP_W+3:0]     winI,
  output logic signed [CHIP_W+3:0]     winQ
);
  localparam int SUM_W = CHIP_W + 4;
  localparam int MAG_W = SUM_W + 1;
  localparam int NQ    = 4;

  typedef logic signed [SUM_W-1:0] sval_t;

  // rotate by -90 degrees times p
  function automatic sval_t rotRe(input sval_t re, input sval_t im, input logic [1:0] p);
    unique case (p)
      2'd0: return re;
      2'd1: return im;
      2'd2: return -re;
      default: return -im;
    endcase
  endfunction

  function automatic sval_t rotIm(input sval_t re, input sval_t im, input logic [1:0] p);
    unique case (p)
      2'd0: return im;
      2'd1: return -re;
      2'd2: return -im;
      default: return re;
    endcase
  endfunction

  function automatic logic [MAG_W-1:0] absV(input sval_t v);
    return (v < 0) ? MAG_W'(-v) : MAG_W'(v);
  endfunction

  sval_t cRe [NCHIP];
  sval_t cIm [NCHIP];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int n = 0; n < NCHIP; n++) begin
        cRe[n] <= '0;
        cIm[n] <= '0;
      end
    end else if (ctrl.load) begin
      for (int n = 0; n < NCHIP; n++) begin
        cRe[n] <= SUM_W'(signed'(chipI[n*CHIP_W +: CHIP_W]));
        cIm[n] <= SUM_W'(signed'(chipQ[n*CHIP_W +: CHIP_W]));
      end
    end
  end

  // stage 1: per p2, pair-wise butterflies
  sval_t aHiRe [NQ], aHiIm [NQ], bHiRe [NQ], bHiIm [NQ];
  sval_t aLoRe [NQ], aLoIm [NQ], bLoRe [NQ], bLoIm [NQ];
  // stage 2: per {p3,p2}, half-block sums
  sval_t sHiRe [NQ*NQ], sHiIm [NQ*NQ], sLoRe [NQ*NQ], sLoIm [NQ*NQ];

  for (genvar g2 = 0; g2 < NQ; g2++) begin : g_stage1
    assign aHiRe[g2] = rotRe(cRe[0], cIm[0], 2'(g2)) + cRe[1];
    assign aHiIm[g2] = rotIm(cRe[0], cIm[0], 2'(g2)) + cIm[1];
    assign bHiRe[g2] = rotRe(cRe[2], cIm[2], 2'(g2)) - cRe[3];
    assign bHiIm[g2] = rotIm(cRe[2], cIm[2], 2'(g2)) - cIm[3];
    assign aLoRe[g2] = rotRe(cRe[4], cIm[4], 2'(g2)) + cRe[5];
    assign aLoIm[g2] = rotIm(cRe[4], cIm[4], 2'(g2)) + cIm[5];
    assign bLoRe[g2] = cRe[7] - rotRe(cRe[6], cIm[6], 2'(g2));
    assign bLoIm[g2] = cIm[7] - rotIm(cRe[6], cIm[6], 2'(g2));
    for (genvar g3 = 0; g3 < NQ; g3++) begin : g_stage2
      assign sHiRe[g3*NQ+g2] = rotRe(aHiRe[g2], aHiIm[g2], 2'(g3)) + bHiRe[g2];
      assign sHiIm[g3*NQ+g2] = rotIm(aHiRe[g2], aHiIm[g2], 2'(g3)) + bHiIm[g2];
      assign sLoRe[g3*NQ+g2] = rotRe(aLoRe[g2], aLoIm[g2], 2'(g3)) + bLoRe[g2];
      assign sLoIm[g3*NQ+g2] = rotIm(aLoRe[g2], aLoIm[g2], 2'(g3)) + bLoIm[g2];
    end
  end

  // stage 3: one candidate per cycle
  logic [3:0]       pairSel;
  logic [1:0]       p4;
  sval_t            candRe, candIm;
  logic [MAG_W-1:0] candMag;
  logic             take;

  logic [MAG_W-1:0] bestMag;
  sval_t            bestRe, bestIm;
  logic [IDX_W-1:0] bestIdx;

  assign pairSel = ctrl.candCode[3:0];
  assign p4      = ctrl.candCode[5:4];
  assign candRe  = rotRe(sHiRe[pairSel], sHiIm[pairSel], p4) + sLoRe[pairSel];
  assign candIm  = rotIm(sHiRe[pairSel], sHiIm[pairSel], p4) + sLoIm[pairSel];
  assign candMag = absV(candRe) + absV(candIm);
  assign take    = ctrl.first || (candMag > bestMag);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bestMag <= '0;
      bestRe  <= '0;
      bestIm  <= '0;
      bestIdx <= '0;
      done    <= 1'b0;
      symIdx  <= '0;
      winI    <= '0;
      winQ    <= '0;
    end else begin
      done <= ctrl.finish;
      if (ctrl.eval && take) begin
        bestMag <= candMag;
        bestRe  <= candRe;
        bestIm  <= candIm;
        bestIdx <= ctrl.candIdx;
      end
      if (ctrl.finish) begin
        symIdx <= take ? ctrl.candIdx : bestIdx;
        winI   <= take ? candRe : bestRe;
        winQ   <= take ? candIm : bestIm;
      end
    end
  end
endmodule

// File: rtl/cck_walsh_picker.sv
module cck_walsh_picker
  import cck_pkg::*;
#(
  parameter int CHIP_W = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     start,
  input  logic                     mode64,
  input  logic [8*CHIP_W-1:0]      chipI,
  input  logic [8*CHIP_W-1:0]      chipQ,
  output logic                     done,
  output logic [5:0]               symIdx,
  output logic signed [CHIP_W+3:0] winI,
  output logic signed [CHIP_W+3:0] winQ
);
  localparam int SUM_W = CHIP_W + 4;

  ctrl_t ctrl;

  cck_ctrl i_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .mode64 (mode64),
    .ctrl   (ctrl)
  );

  cck_datapath #(.CHIP_W(CHIP_W)) i_dp (
    .clk    (clk),
    .rstN   (rstN),
    .ctrl   (ctrl),
    .chipI  (chipI),
    .chipQ  (chipQ),
    .done   (done),
    .symIdx (symIdx),
    .winI   (winI),
    .winQ   (winQ)
  );
endmodule

// File: rtl/cck_walsh_picker_chk.sv
module cck_walsh_picker_chk #(
  parameter int SUM_W = 12
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             mode64,
  input logic             done,
  input logic [5:0]       symIdx,
  input logic [SUM_W-1:0] winI,
  input logic [SUM_W-1:0] winQ
);
  logic       busy;
  logic       wide;
  logic [6:0] since;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy  <= 1'b0;
      wide  <= 1'b0;
      since <= '0;
    end else if (start && (!busy || done)) begin
      busy  <= 1'b1;
      wide  <= mode64;
      since <= '0;
    end else if (busy) begin
      if (done) busy <= 1'b0;
      else      since <= since + 1'b1;
    end
  end

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_latency_r6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (busy && (since == (wide ? 7'd64 : 7'd4))));

  p_narrow_idx_r3: assert property (@(posedge clk) disable iff (!rstN)
    (done && !wide) |-> (symIdx[5:2] == 4'd0));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable({symIdx, winI, winQ}));

  p_no_idle_done_r7: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !done);
endmodule

bind cck_walsh_picker cck_walsh_picker_chk #(.SUM_W(SUM_W)) i_chk (
  .clk    (clk),
  .rstN   (rstN),
  .start  (start),
  .mode64 (mode64),
  .done   (done),
  .symIdx (symIdx),
  .winI   (winI),
  .winQ   (winQ)
);

// File: tb/test_cck_walsh_picker.sv
module test_cck_walsh_picker;
  localparam int CW = 8;
  localparam int SW = CW + 4;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             start = 1'b0;
  logic             mode64 = 1'b0;
  logic [8*CW-1:0]  chipI = '0;
  logic [8*CW-1:0]  chipQ = '0;
  logic             done;
  logic [5:0]       symIdx;
  logic signed [SW-1:0] winI, winQ;

  cck_walsh_picker #(.CHIP_W(CW)) i_cck_walsh_picker (
    .clk(clk), .rstN(rstN), .start(start), .mode64(mode64),
    .chipI(chipI), .chipQ(chipQ), .done(done),
    .symIdx(symIdx), .winI(winI), .winQ(winQ)
  );

  always #5 clk = ~clk;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  typedef struct packed {
    logic              wide;
    logic [5:0]        sym;
    logic signed [7:0] amp;
    logic [1:0]        rot;
    logic [7:0]        noise;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 6'd0,  8'sd10,  2'd0, 8'd0},
    '{1'b1, 6'd37, 8'sd12,  2'd1, 8'd5},
    '{1'b1, 6'd63, 8'sd9,   2'd2, 8'd11},
    '{1'b1, 6'd22, 8'sd15,  2'd3, 8'd3},
    '{1'b0, 6'd0,  8'sd14,  2'd0, 8'd0},
    '{1'b0, 6'd1,  8'sd11,  2'd1, 8'd7},
    '{1'b0, 6'd2,  8'sd13,  2'd2, 8'd2},
    '{1'b0, 6'd3,  8'sd10,  2'd3, 8'd9},
    '{1'b1, 6'd45, 8'sd100, 2'd0, 8'd6}
  };

  int rI [8];
  int rQ [8];
  int expIdx, expRe, expIm;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int codePhase(input int n, input int q2, input int q3, input int q4);
    int ph;
    case (n)
      0: ph = q2 + q3 + q4;
      1: ph = q3 + q4;
      2: ph = q2 + q4;
      3: ph = q4 + 2;
      4: ph = q2 + q3;
      5: ph = q3;
      6: ph = q2 + 2;
      default: ph = 0;
    endcase
    return ph % 4;
  endfunction

  task automatic candPhases(input bit wide, input int k, output int q2, output int q3, output int q4);
    if (wide) begin
      q2 = k % 4; q3 = (k / 4) % 4; q4 = (k / 16) % 4;
    end else begin
      q2 = (k % 2) ? 3 : 1; q3 = 0; q4 = ((k / 2) % 2) ? 2 : 0;
    end
  endtask

  task automatic buildChips(input vec_t v);
    int q2, q3, q4, ph, nzI, nzQ;
    candPhases(v.wide, int'(v.sym), q2, q3, q4);
    for (int n = 0; n < 8; n++) begin
      ph = (codePhase(n, q2, q3, q4) + int'(v.rot)) % 4;
      nzI = (v.noise == 0) ? 0 : ((int'(v.noise) * (n * 5 + 3) + n) % 9) - 4;
      nzQ = (v.noise == 0) ? 0 : ((int'(v.noise) * (n * 3 + 1) + 2 * n) % 9) - 4;
      case (ph)
        0: begin rI[n] = int'(v.amp);  rQ[n] = 0; end
        1: begin rI[n] = 0;  rQ[n] = int'(v.amp); end
        2: begin rI[n] = -int'(v.amp); rQ[n] = 0; end
        default: begin rI[n] = 0; rQ[n] = -int'(v.amp); end
      endcase
      rI[n] += nzI;
      rQ[n] += nzQ;
    end
  endtask

  // direct per-chip correlation and pick, from R2..R5
  task automatic model(input bit wide);
    int q2, q3, q4, ph, cr, ci, mag, best, tr, ti;
    best = -1;
    for (int k = 0; k < (wide ? 64 : 4); k++) begin
      candPhases(wide, k, q2, q3, q4);
      cr = 0; ci = 0;
      for (int n = 0; n < 8; n++) begin
        ph = codePhase(n, q2, q3, q4);
        case (ph)
          0: begin tr = rI[n];  ti = rQ[n];  end
          1: begin tr = rQ[n];  ti = -rI[n]; end
          2: begin tr = -rI[n]; ti = -rQ[n]; end
          default: begin tr = -rQ[n]; ti = rI[n]; end
        endcase
        cr += tr; ci += ti;
      end
      mag = (cr < 0 ? -cr : cr) + (ci < 0 ? -ci : ci);
      if (mag > best) begin
        best = mag; expIdx = k; expRe = cr; expIm = ci;
      end
    end
  endtask

  task automatic driveChips();
    for (int n = 0; n < 8; n++) begin
      chipI[n*CW +: CW] = CW'(rI[n]);
      chipQ[n*CW +: CW] = CW'(rQ[n]);
    end
  endtask

  // start a search and watch done; interfereAt > 0 pokes start mid-search
  task automatic runSym(input bit wide, input string req, input int interfereAt);
    int N;
    bit dBefore, dAt, dAfter;
    N = wide ? 64 : 4;
    @(negedge clk);
    mode64 = wide;
    driveChips();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 1; k <= N; k++) begin
      @(negedge clk);
      if (k == interfereAt) begin
        start = 1'b1; mode64 = ~wide;
        chipI = ~chipI; chipQ = chipQ ^ 64'h5a5a5a5a5a5a5a5a;
      end else if (k == interfereAt + 1) begin
        start = 1'b0;
      end
      if (k == N - 1) dBefore = done;
      if (k == N) dAt = done;
    end
    start = 1'b0;
    @(negedge clk);
    dAfter = done;
    check(!dBefore && dAt && !dAfter, "R6", "done timing",
          {29'd0, dBefore, dAt, dAfter}, 3'b010);
  endtask

  task automatic checkResult(input string req);
    check(int'(symIdx) == expIdx, req, "index", int'(symIdx), expIdx);
    check(int'(winI) == expRe, "R4", "winner I", int'(winI), expRe);
    check(int'(winQ) == expIm, "R4", "winner Q", int'(winQ), expIm);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++; tests++;
      $display("FAIL watchdog: actual %0d expected <= 100000 cycles", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(done == 1'b0, "R1", "done in reset", int'(done), 0);
    check(symIdx == '0 && winI == '0 && winQ == '0, "R1", "outputs in reset",
          int'(symIdx) + int'(winI) + int'(winQ), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(done == 1'b0 && symIdx == '0 && winI == '0, "R1", "after reset",
          int'(done) + int'(symIdx) + int'(winI), 0);

    // table-driven symbols (R2, R3, R4, R6)
    for (int v = 0; v < NV; v++) begin
      buildChips(VECS[v]);
      model(VECS[v].wide);
      runSym(VECS[v].wide, VECS[v].wide ? "R2" : "R3", 0);
      checkResult(VECS[v].wide ? "R2" : "R3");
      if (!VECS[v].wide)
        check(symIdx[5:2] == 4'd0, "R3", "narrow upper index bits", int'(symIdx[5:2]), 0);
      if (v == 0)
        check(winI == 80 && winQ == 0 && symIdx == 0, "R4", "clean code 0 value",
              int'(winI), 80);
      if (v == 4)
        check(winI == 112 && winQ == 0 && symIdx == 0, "R4", "clean narrow code value",
              int'(winI), 112);
    end

    // R5: all-zero block ties everywhere, lowest index wins
    for (int w = 0; w < 2; w++) begin
      for (int n = 0; n < 8; n++) begin rI[n] = 0; rQ[n] = 0; end
      runSym(w[0], "R5", 0);
      check(symIdx == 0 && winI == 0 && winQ == 0, "R5", "tie to lowest index",
            int'(symIdx), 0);
    end

    // R9: most negative value on every chip
    for (int n = 0; n < 8; n++) begin rI[n] = -128; rQ[n] = -128; end
    model(1'b1);
    runSym(1'b1, "R9", 0);
    checkResult("R9");

    // R7: start, mode and chips changed mid-search are ignored
    buildChips(VECS[1]);
    model(1'b1);
    runSym(1'b1, "R7", 10);
    checkResult("R7");
    begin
      int extra = 0;
      for (int k = 0; k < 70; k++) begin
        @(negedge clk);
        if (done) extra++;
      end
      check(extra == 0, "R7", "no extra done", extra, 0);
    end

    // R8: outputs hold with inputs changing and no start
    begin
      int changed = 0;
      mode64 = 1'b0;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        chipI = chipI + 64'h0101010101010101;
        chipQ = ~chipQ;
        if (int'(symIdx) != expIdx || int'(winI) != expRe || int'(winQ) != expIm) changed++;
      end
      check(changed == 0, "R8", "outputs held", changed, 0);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule